// File: doc/BRIEF.md
# 2x2 Stride-2 Pooling Engine

This block shrinks a square feature map by half in each dimension. Every output is taken from one non-overlapping 2x2 window of the input. The input map is held in an on-block register array, and a single write port loads it one element at a time. A start pulse launches a pass. A sequencer then walks the windows in raster order and hands one window per cycle to a reduction pipeline. The pipeline returns one pooled value per cycle, each marked with a valid strobe and the output index.

A compile-time parameter picks the reduction. The default takes the signed maximum of the four values through a two-level comparator tree. The other setting takes the floored mean: it adds the four values in three chained adder stages and then does an arithmetic shift right by two. The mean setting therefore has three more cycles of latency than the maximum setting. Pooling has no learned coefficients; only the window size and the stride define it.

The control state machine has four states:
- IDLE waits for start.
- ISSUE sends one window per cycle.
- DRAIN waits for the last result to leave the pipeline.
- FINISH raises done for one cycle.

The transitions are:
- start-accepted: IDLE to ISSUE.
- last-window-sent: ISSUE to DRAIN.
- last-result-seen: DRAIN to FINISH.
- pass-closed: FINISH to IDLE.

Top module: `pool2x2_engine`

## Requirements
- R1: After reset, out_valid, done and busy are low. While busy is low, out_valid and done stay low.
- R2: When wr_en is high at a clock edge, wr_data is stored at map element (row, col), where wr_addr = row*8 + col (row in the upper three bits, col in the lower three).
- R3: One pass produces exactly 16 outputs with out_index 0..15 in increasing order. Index i = 4*r + c covers input elements (2r,2c), (2r,2c+1), (2r+1,2c) and (2r+1,2c+1).
- R4: In the default maximum setting, out_data is the largest of the four window values, compared as signed two's complement.
- R5: In the mean setting, out_data is the sum of the four signed values, formed without overflow, shifted right arithmetically by two. The result is rounded toward negative infinity.
- R6: Index 0 appears 3 cycles after the edge that samples start in the maximum setting, and 6 cycles after it in the mean setting. The remaining indices follow on consecutive cycles.
- R7: done is a single-cycle pulse in the cycle after the one that carries index 15. busy is high from the cycle after start is accepted through the done cycle, and low after it.
- R8: A start pulse that arrives while busy is high is ignored. The running pass keeps its order and timing, and no second pass begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Map element write strobe |
| wr_addr | input | 6 | Element address, row*8 + col |
| wr_data | input | 16 | Signed element value |
| start | input | 1 | Launches one pooling pass |
| busy | output | 1 | Pass in progress |
| out_valid | output | 1 | Pooled value strobe |
| out_index | output | 4 | Output position, 4*r + c |
| out_data | output | 16 | Pooled signed value |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench drives two instances from the same inputs, one in each reduction setting, and checks every cycle of every pass against a map held in the bench.

It targets the following corner cases:
- Maps filled with the most negative and the most positive values. An unsigned compare, or a mean sum too narrow to hold four values, would return a wrong extreme or a wrapped value.
- Maps of small negative values. A divide that truncates toward zero would be off by one against the floored mean.
- Maps of equal values, which exercise ties in the comparator tree.
- A start pulse in the middle of a pass. A sequencer that restarts on it would repeat indices, shift later outputs, or emit a second done.

// File: rtl/pool_pkg.sv
package pool_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_DRAIN,
        SQ_FINISH
    } sq_state_t;

    localparam int MAX_LAT  = 2;
    localparam int MEAN_LAT = 5;

    function automatic int reduce_latency(input bit mean_mode);
        return mean_mode ? MEAN_LAT : MAX_LAT;
    endfunction

endpackage

// File: rtl/pool_sequencer.sv
module pool_sequencer
    import pool_pkg::*;
#(
    parameter int RC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            last_result,
    output logic            rd_strobe,
    output logic [RC_W-1:0] rd_row,
    output logic [RC_W-1:0] rd_col,
    output logic            busy,
    output logic            done
);

    localparam logic [RC_W-1:0] RC_MAX = {RC_W{1'b1}};

    sq_state_t       state_q, state_d;
    logic [RC_W-1:0] row_q, col_q;
    logic            at_last;

    assign at_last = (row_q == RC_MAX) && (col_q == RC_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start)       state_d = SQ_ISSUE;
            SQ_ISSUE:  if (at_last)     state_d = SQ_DRAIN;
            SQ_DRAIN:  if (last_result) state_d = SQ_FINISH;
            SQ_FINISH:                  state_d = SQ_IDLE;
            default:                    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (state_q == SQ_IDLE && start) begin
            row_q <= '0;
            col_q <= '0;
        end else if (state_q == SQ_ISSUE) begin
            col_q <= col_q + 1'b1;
            if (col_q == RC_MAX) row_q <= row_q + 1'b1;
        end
    end

    always_comb begin
        rd_strobe = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            SQ_IDLE:   busy      = 1'b0;
            SQ_ISSUE:  rd_strobe = 1'b1;
            SQ_DRAIN:  ;
            SQ_FINISH: done      = 1'b1;
            default:   busy      = 1'b0;
        endcase
    end

    assign rd_row = row_q;
    assign rd_col = col_q;

    // R8: a start inside a pass must not rewind the window walk
    p_walk_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ISSUE && $past(state_q) == SQ_ISSUE) |->
            ({row_q, col_q} == $past({row_q, col_q}) + 1'b1));

    // R3: the last window always hands over to draining
    p_last_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ISSUE && at_last) |=> (state_q == SQ_DRAIN));

endmodule

// File: rtl/pool_mapbuf.sv
module pool_mapbuf #(
    parameter int DATA_W = 16,
    parameter int RC_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2*RC_W+1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_strobe,
    input  logic [RC_W-1:0]        rd_row,
    input  logic [RC_W-1:0]        rd_col,
    output logic                   win_valid,
    output logic [2*RC_W-1:0]      win_idx,
    output logic [3:0][DATA_W-1:0] win
);

    localparam int ADDR_W = 2 * RC_W + 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] tap [4];

    // tap k: vertical offset k[1], horizontal offset k[0]
    for (genvar k = 0; k < 4; k++) begin : g_tap
        assign tap[k] = {rd_row, k[1], rd_col, k[0]};
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_valid <= 1'b0;
        else        win_valid <= rd_strobe;
    end

    always_ff @(posedge clk) begin
        if (rd_strobe) begin
            win_idx <= {rd_row, rd_col};
            for (int k = 0; k < 4; k++) win[k] <= mem[tap[k]];
        end
    end

    // R3: a window is presented only in the cycle after a read request
    p_win_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $past(rd_strobe));

endmodule

// File: rtl/pool_reduce.sv
module pool_reduce
    import pool_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int IDX_W     = 4,
    parameter bit POOL_MEAN = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [IDX_W-1:0]       in_idx,
    input  logic [3:0][DATA_W-1:0] in_win,
    output logic                   res_valid,
    output logic [IDX_W-1:0]       res_idx,
    output logic [DATA_W-1:0]      res_data
);

    localparam int LAT   = reduce_latency(POOL_MEAN);
    localparam int SUM_W = DATA_W + 2;

    logic signed [DATA_W-1:0] va, vb, vc, vd;
    assign va = in_win[0];
    assign vb = in_win[1];
    assign vc = in_win[2];
    assign vd = in_win[3];

    logic             v_sr   [LAT];
    logic [IDX_W-1:0] idx_sr [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) v_sr[i] <= 1'b0;
        end else begin
            v_sr[0] <= in_valid;
            for (int i = 1; i < LAT; i++) v_sr[i] <= v_sr[i-1];
        end
    end

    always_ff @(posedge clk) begin
        idx_sr[0] <= in_idx;
        for (int i = 1; i < LAT; i++) idx_sr[i] <= idx_sr[i-1];
    end

    assign res_valid = v_sr[LAT-1];
    assign res_idx   = idx_sr[LAT-1];

    if (POOL_MEAN) begin : g_mean
        logic signed [SUM_W-1:0]  s1_q, s2_q, s3_q, in_sum;
        logic signed [DATA_W-1:0] c1_q, d1_q, d2_q, q4_q, out_q;

        always_ff @(posedge clk) begin
            s1_q  <= SUM_W'(va) + SUM_W'(vb);
            c1_q  <= vc;
            d1_q  <= vd;
            s2_q  <= s1_q + SUM_W'(c1_q);
            d2_q  <= d1_q;
            s3_q  <= s2_q + SUM_W'(d2_q);
            q4_q  <= DATA_W'(s3_q >>> 2);
            out_q <= q4_q;
        end
        assign res_data = out_q;

        assign in_sum = SUM_W'(va) + SUM_W'(vb) + SUM_W'(vc) + SUM_W'(vd);

        // R5: the result is the floor of the quarter of the window sum
        p_mean_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            v_sr[LAT-1] |->
                ((int'(out_q) * 4 <= int'($past(in_sum, 5))) &&
                 (int'($past(in_sum, 5)) - int'(out_q) * 4 < 4)));
    end else begin : g_max
        logic signed [DATA_W-1:0] m01_q, m23_q, out_q;

        always_ff @(posedge clk) begin
            m01_q <= (va >= vb) ? va : vb;
            m23_q <= (vc >= vd) ? vc : vd;
            out_q <= (m01_q >= m23_q) ? m01_q : m23_q;
        end
        assign res_data = out_q;

        // R4: the result bounds every value of its window, signed
        p_max_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            v_sr[LAT-1] |->
                ((out_q >= $past(va, 2)) && (out_q >= $past(vb, 2)) &&
                 (out_q >= $past(vc, 2)) && (out_q >= $past(vd, 2))));
    end

endmodule

// File: rtl/pool2x2_engine.sv
module pool2x2_engine
    import pool_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAP_DIM   = 8,
    parameter bit POOL_MEAN = 1'b0,
    localparam int RC_W     = $clog2(MAP_DIM) - 1,
    localparam int IDX_W    = 2 * RC_W,
    localparam int ADDR_W   = 2 * RC_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_index,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic                   rd_strobe;
    logic [RC_W-1:0]        rd_row, rd_col;
    logic                   win_valid;
    logic [IDX_W-1:0]       win_idx;
    logic [3:0][DATA_W-1:0] win;
    logic                   last_result;

    assign last_result = out_valid && (out_index == LAST_IDX);

    pool_sequencer #(.RC_W(RC_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .last_result (last_result),
        .rd_strobe   (rd_strobe),
        .rd_row      (rd_row),
        .rd_col      (rd_col),
        .busy        (busy),
        .done        (done)
    );

    pool_mapbuf #(.DATA_W(DATA_W), .RC_W(RC_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_strobe (rd_strobe),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win       (win)
    );

    pool_reduce #(.DATA_W(DATA_W), .IDX_W(IDX_W), .POOL_MEAN(POOL_MEAN)) u_red (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (win_valid),
        .in_idx    (win_idx),
        .in_win    (win),
        .res_valid (out_valid),
        .res_idx   (out_index),
        .res_data  (out_data)
    );

    // R1: no result and no end pulse outside a pass
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !done));

    // R6: back-to-back results step the index by one
    p_index_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_index == $past(out_index) + 1'b1));

    // R7: done follows the final index by exactly one cycle
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_index) == LAST_IDX));

endmodule

// File: tb/pool2x2_engine_tb.sv
`timescale 1ns/1ps
module pool2x2_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;

    logic        busy_x, valid_x, done_x;
    logic [3:0]  idx_x;
    logic [15:0] data_x;
    logic        busy_m, valid_m, done_m;
    logic [3:0]  idx_m;
    logic [15:0] data_m;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    int map_m [64];

    always #2.5 clk = ~clk;

    pool2x2_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .busy(busy_x), .out_valid(valid_x),
        .out_index(idx_x), .out_data(data_x), .done(done_x)
    );

    pool2x2_engine #(.POOL_MEAN(1'b1)) u_dut_mean (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .busy(busy_m), .out_valid(valid_m),
        .out_index(idx_m), .out_data(data_m), .done(done_m)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int elem(input int r, input int c);
        return map_m[r * 8 + c];
    endfunction

    function automatic int exp_max(input int i);
        int r = i / 4, c = i % 4, m;
        m = elem(2*r, 2*c);
        if (elem(2*r, 2*c+1)   > m) m = elem(2*r, 2*c+1);
        if (elem(2*r+1, 2*c)   > m) m = elem(2*r+1, 2*c);
        if (elem(2*r+1, 2*c+1) > m) m = elem(2*r+1, 2*c+1);
        return m;
    endfunction

    function automatic int exp_mean(input int i);
        int r = i / 4, c = i % 4, s;
        s = elem(2*r, 2*c) + elem(2*r, 2*c+1) + elem(2*r+1, 2*c) + elem(2*r+1, 2*c+1);
        return s >>> 2;
    endfunction

    // R2: address = row*8 + col
    task automatic put(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 6'(a);
        wr_data = 16'(v);
        map_m[a] = int'($signed(16'(v)));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_dut(input string tag, input int k, input int lat,
                             input logic v, input logic [3:0] ix, input logic [15:0] d,
                             input logic dn, input logic bz, input bit mean);
        int first = lat + 1;
        bit ev = (k >= first) && (k <= first + 15);
        chk(v == ev, {tag, " R6 out_valid timing"}, int'(v), int'(ev));
        if (ev && v) begin
            chk(int'(ix) == k - first, {tag, " R3 index order"}, int'(ix), k - first);
            if (mean)
                chk(int'($signed(d)) == exp_mean(k - first), {tag, " R5 mean value"},
                    int'($signed(d)), exp_mean(k - first));
            else
                chk(int'($signed(d)) == exp_max(k - first), {tag, " R4 max value"},
                    int'($signed(d)), exp_max(k - first));
        end
        chk(dn == (k == first + 16), {tag, " R7 done pulse"}, int'(dn), int'(k == first + 16));
        chk(bz == (k <= first + 16), {tag, " R7 busy span"}, int'(bz), int'(k <= first + 16));
    endtask

    task automatic run_pass(input bit poke);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= 25; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check_dut("max", k, 2, valid_x, idx_x, data_x, done_x, busy_x, 1'b0);
            check_dut("mean", k, 5, valid_m, idx_m, data_m, done_m, busy_m, 1'b1);
            // R8: start pulse in mid-pass must be ignored
            start = (poke && k == 5) ? 1'b1 : 1'b0;
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset and just after
        chk(!valid_x && !done_x && !busy_x, "R1 reset state max", int'(valid_x | done_x | busy_x), 0);
        chk(!valid_m && !done_m && !busy_m, "R1 reset state mean", int'(valid_m | done_m | busy_m), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_x && !busy_x && !valid_m && !busy_m, "R1 idle after reset",
            int'(valid_x | busy_x | valid_m | busy_m), 0);

        // R4 R5 most negative everywhere
        for (int a = 0; a < 64; a++) put(a, -32768);
        run_pass(1'b0);
        // R4 R5 most positive everywhere
        for (int a = 0; a < 64; a++) put(a, 32767);
        run_pass(1'b0);
        // ties: all equal
        for (int a = 0; a < 64; a++) put(a, -7);
        run_pass(1'b0);
        // R5 floor rounding with small negative values
        for (int a = 0; a < 64; a++) put(a, (a % 3 == 0) ? -1 : ((a % 5 == 0) ? 2 : 0));
        run_pass(1'b0);
        // R2 R3 position sensitive pattern
        for (int a = 0; a < 64; a++) put(a, a * 97 - 3000);
        run_pass(1'b1);
        // random maps
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 64; a++) put(a, int'($urandom() & 32'hFFFF));
            run_pass(p == 2);
        end
        // R2 single-element overwrite then rerun
        put(27, 32767);
        put(36, -32768);
        run_pass(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule